// File: doc/BRIEF.md
# Routed Interrupt Controller, 32 Sources

This block gathers 32 interrupt request lines and steers each one to one of four parent interrupt outputs. Each source has its own trigger configuration: it can be level or edge sensitive, and it can be active high or active low. Edge sources pass through a two-flop synchroniser. A detected edge sets a sticky pending bit, and software clears that bit by writing 1 to it. Level sources report their live level, qualified by polarity.

Each source also has a routing byte. The upper nibble names the parent output. The lower nibble names the processor cores that may receive the source. A source reaches a parent output only when it is enabled and active, and only when its core nibble includes the core this instance watches (parameter `OBS_CORE`, default core 0).

Software reaches the block through a simple register port. Writes take effect at the clock edge where the request is seen. Read data returns one cycle after the request. The enable mask is changed only through separate set and clear registers. Software services pending sources starting from the lowest set bit.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable mask, polarity register, edge register, pending status and all route bytes read as 0, and every parent output is 0.
- R2: A write to offset 0x28 sets the enable bits where the write data holds 1. Zero bits leave their enables unchanged. Offset 0x24 reads back the current enable mask.
- R3: A write to offset 0x2C clears the enable bits where the write data holds 1. Writing all ones disables every source.
- R4: With edge bit = 0 (offset 0x34), a source is active while its input equals its polarity bit (offset 0x30: 1 = high, 0 = low). The status register at offset 0x40 returns the active sources AND the enable mask.
- R5: With edge bit = 1, a polarity bit of 1 latches pending on a rising edge and a polarity bit of 0 latches pending on a falling edge. The pending bit stays set after the input returns to its idle level.
- R6: Writing 1 to a bit at offset 0x40 clears that source's latched edge pending. Zero bits have no effect.
- R7: Route byte i sits at byte offset i (0x00 to 0x1F) in write data bits 7:0 and reads back there. Parent output k is 1 when some enabled, active source has route bit 4+k set and route bit OBS_CORE set (bits 3:0 form the core mask).
- R8: A source whose route core bits exclude the observed core drives no parent output, even when it is enabled and active.
- R9: Every read request gives `reg_rvalid` = 1 in exactly the next cycle, with the data in `reg_rdata`. `reg_rvalid` is 0 in a cycle that follows no read request.
- R10: Writes to undefined offsets change no register. Reads from undefined offsets, and from the write-only offsets 0x28 and 0x2C, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt source inputs |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| parent_irq | output | 4 | Parent interrupt outputs |

## Verification
A bad enable bit appears at offset 0x24 on the next read. It also shows as a missing or extra status bit and parent assertion as soon as that source becomes active. A stuck or lost edge pending bit is visible in the status register and on the routed parent output about three cycles after the input edge. From there it persists until a clear write, so a wrong sticky state is never hidden by the input returning idle. A routing error appears on the parent outputs in the same cycle that the source's qualified status changes.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_EN_STAT = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_EN_SET  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_POL     = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_EDGE    = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_PEND    = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ROUTE, SEL_EN_STAT, SEL_EN_SET,
    SEL_EN_CLR, SEL_POL, SEL_EDGE, SEL_PEND
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a,
                                          input int unsigned nsrc);
    reg_sel_e r;
    r = SEL_NONE;
    if (32'(a) < nsrc) r = SEL_ROUTE;
    else begin
      case (a)
        OFF_EN_STAT: r = SEL_EN_STAT;
        OFF_EN_SET:  r = SEL_EN_SET;
        OFF_EN_CLR:  r = SEL_EN_CLR;
        OFF_POL:     r = SEL_POL;
        OFF_EDGE:    r = SEL_EDGE;
        OFF_PEND:    r = SEL_PEND;
        default:     r = SEL_NONE;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic pol,
  input  logic edge_sel,
  input  logic pend_clr,
  output logic active_o
);
  logic s1_q, s2_q, s3_q, pend_q;
  logic det, pend_d;

  // Edge detection on the synchronised input; a detection wins over a clear.
  always_comb begin
    det    = pol ? (s2_q & ~s3_q) : (~s2_q & s3_q);
    pend_d = det | (pend_q & ~pend_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign active_o = edge_sel ? pend_q : (pol ? s2_q : ~s2_q);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int RW      = 8,
  parameter int DATA_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_SRC-1:0]           pend_status,
  output logic [NUM_SRC-1:0]           enable_o,
  output logic [NUM_SRC-1:0]           pol_o,
  output logic [NUM_SRC-1:0]           edge_o,
  output logic [NUM_SRC-1:0][RW-1:0]   route_o,
  output logic [NUM_SRC-1:0]           pend_clr_o,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rvalid
);
  localparam int SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e sel;
  logic wr, rd;
  logic [NUM_SRC-1:0]         en_q, en_d, pol_q, pol_d, edge_q, edge_d;
  logic [NUM_SRC-1:0][RW-1:0] route_q, route_d;
  logic [DATA_W-1:0]          rdata_q, rdata_d;
  logic                       rvalid_q;
  logic                       cfg_upd;

  always_comb begin
    sel = decode_sel(addr, NUM_SRC);
    wr  = req & we;
    rd  = req & ~we;
    cfg_upd = wr & (sel != SEL_NONE) & (sel != SEL_PEND) & (sel != SEL_EN_STAT);

    en_d    = en_q;
    pol_d   = pol_q;
    edge_d  = edge_q;
    route_d = route_q;
    pend_clr_o = '0;
    if (wr) begin
      case (sel)
        SEL_EN_SET: en_d   = en_q | wdata[NUM_SRC-1:0];
        SEL_EN_CLR: en_d   = en_q & ~wdata[NUM_SRC-1:0];
        SEL_POL:    pol_d  = wdata[NUM_SRC-1:0];
        SEL_EDGE:   edge_d = wdata[NUM_SRC-1:0];
        SEL_PEND:   pend_clr_o = wdata[NUM_SRC-1:0];
        SEL_ROUTE:  route_d[addr[SIDX_W-1:0]] = wdata[RW-1:0];
        default: ;
      endcase
    end

    rdata_d = '0;
    case (sel)
      SEL_ROUTE:   rdata_d[RW-1:0]      = route_q[addr[SIDX_W-1:0]];
      SEL_EN_STAT: rdata_d[NUM_SRC-1:0] = en_q;
      SEL_POL:     rdata_d[NUM_SRC-1:0] = pol_q;
      SEL_EDGE:    rdata_d[NUM_SRC-1:0] = edge_q;
      SEL_PEND:    rdata_d[NUM_SRC-1:0] = pend_status;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      route_q <= '0;
    end else if (cfg_upd) begin
      en_q    <= en_d;
      pol_q   <= pol_d;
      edge_q  <= edge_d;
      route_q <= route_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign enable_o = en_q;
  assign pol_o    = pol_q;
  assign edge_o   = edge_q;
  assign route_o  = route_q;
  assign rdata    = rdata_q;
  assign rvalid   = rvalid_q;
endmodule

// File: rtl/irq_parent_merge.sv
module irq_parent_merge #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PAR  = 4,
  parameter int NUM_CORE = 4,
  parameter int OBS_CORE = 0
) (
  input  logic [NUM_SRC-1:0]                        status,
  input  logic [NUM_SRC-1:0][NUM_PAR+NUM_CORE-1:0]  route,
  output logic [NUM_PAR-1:0]                        parent_o
);
  for (genvar k = 0; k < NUM_PAR; k++) begin : g_par
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        hit = hit | (status[i] & route[i][NUM_CORE+k] & route[i][OBS_CORE]);
      end
    end
    assign parent_o[k] = hit;
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PAR  = 4,
  parameter int NUM_CORE = 4,
  parameter int OBS_CORE = 0,
  parameter int DATA_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_rvalid,
  output logic [NUM_PAR-1:0]   parent_irq
);
  localparam int RW = NUM_PAR + NUM_CORE;

  logic [NUM_SRC-1:0]         en_q, pol, edge_sel, pend_clr, active, pend_status;
  logic [NUM_SRC-1:0][RW-1:0] route;

  irq_regfile #(.NUM_SRC(NUM_SRC), .RW(RW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .pend_status(pend_status), .enable_o(en_q),
    .pol_o(pol), .edge_o(edge_sel), .route_o(route), .pend_clr_o(pend_clr),
    .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_cond u_cond (
      .clk(clk), .rst_n(rst_n), .src_i(src_i[i]), .pol(pol[i]),
      .edge_sel(edge_sel[i]), .pend_clr(pend_clr[i]), .active_o(active[i])
    );
  end

  assign pend_status = active & en_q;

  irq_parent_merge #(.NUM_SRC(NUM_SRC), .NUM_PAR(NUM_PAR), .NUM_CORE(NUM_CORE),
                     .OBS_CORE(OBS_CORE)) u_merge (
    .status(pend_status), .route(route), .parent_o(parent_irq)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_PAR = 4,
  parameter int DATA_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_req,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic                reg_rvalid,
  input logic [NUM_PAR-1:0]  parent_irq,
  input logic [NUM_SRC-1:0]  enable,
  input logic [NUM_SRC-1:0]  status
);
  logic rd_req, rd_undef;
  always_comb begin
    rd_req   = reg_req & ~reg_we;
    rd_undef = (decode_sel(reg_addr, NUM_SRC) == SEL_NONE) ||
               (reg_addr == OFF_EN_SET) || (reg_addr == OFF_EN_CLR);
  end

  AST_READ_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> reg_rvalid); // R9
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !reg_rvalid); // R9
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == OFF_EN_SET) |=>
      ((enable & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0]))); // R2
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && reg_we) |=> $stable(enable)); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == OFF_EN_CLR) |=>
      ((enable & $past(reg_wdata[NUM_SRC-1:0])) == '0)); // R3
  AST_PARENT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (parent_irq != '0) |-> (status != '0)); // R7
  AST_STATUS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~enable) == '0)); // R4
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_undef) |=> (reg_rdata == '0)); // R10
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_SRC(NUM_SRC), .NUM_PAR(NUM_PAR), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_rvalid(reg_rvalid), .parent_irq(parent_irq), .enable(en_q),
  .status(pend_status)
);

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [3:0]  parent_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .parent_irq(parent_irq)
  );

  // {edge, pol, v0, v1, expected status bit} for source 5
  localparam logic [4:0] VEC [8] = '{
    5'b0_1_0_1_1, 5'b0_1_1_0_0, 5'b0_0_0_0_1, 5'b0_0_1_1_0,
    5'b1_1_0_1_1, 5'b1_1_1_0_0, 5'b1_0_1_0_1, 5'b1_0_0_1_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_req = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete (expected completion)");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h24, v); chk("R1 enable", v, 32'h0);
    rd(8'h30, v); chk("R1 polarity", v, 32'h0);
    rd(8'h34, v); chk("R1 edge", v, 32'h0);
    rd(8'h40, v); chk("R1 status", v, 32'h0);
    rd(8'h07, v); chk("R1 route", v, 32'h0);
    chk("R1 parent", {28'h0, parent_irq}, 32'h0);

    // R9 read timing
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = 8'h24;
    @(negedge clk);
    reg_req = 1'b0;
    chk("R9 rvalid after read", {31'h0, reg_rvalid}, 32'h1);
    @(negedge clk);
    chk("R9 rvalid idle", {31'h0, reg_rvalid}, 32'h0);

    // R2 enable set
    wr(8'h28, 32'h0000_00F0);
    wr(8'h28, 32'h0000_0003);
    rd(8'h24, v); chk("R2 set accumulates", v, 32'h0000_00F3);
    wr(8'h28, 32'h0);
    rd(8'h24, v); chk("R2 zero bits no effect", v, 32'h0000_00F3);

    // R3 enable clear
    wr(8'h2C, 32'h0000_0010);
    rd(8'h24, v); chk("R3 clear one", v, 32'h0000_00E3);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R3 clear all", v, 32'h0);

    // R10 undefined offsets
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h25, 32'hFFFF_FFFF);
    rd(8'h38, v); chk("R10 undef read", v, 32'h0);
    rd(8'h24, v); chk("R10 undef write ignored", v, 32'h0);
    rd(8'h30, v); chk("R10 pol untouched", v, 32'h0);
    wr(8'h28, 32'h0000_0100);
    rd(8'h28, v); chk("R10 set offset reads zero", v, 32'h0);
    wr(8'h2C, 32'hFFFF_FFFF);

    // R4 R5 table on source 5
    for (int t = 0; t < 8; t++) begin
      wr(8'h2C, 32'hFFFF_FFFF);
      wr(8'h30, {26'h0, VEC[t][3], 5'h0});
      wr(8'h34, {26'h0, VEC[t][4], 5'h0});
      src_i[5] = VEC[t][2];
      settle();
      wr(8'h40, 32'hFFFF_FFFF);
      src_i[5] = VEC[t][1];
      settle();
      wr(8'h28, 32'h0000_0020);
      rd(8'h40, v);
      if (VEC[t][4]) chk("R5 edge vector", v, {26'h0, VEC[t][0], 5'h0});
      else           chk("R4 level vector", v, {26'h0, VEC[t][0], 5'h0});
    end
    src_i = '0;
    wr(8'h2C, 32'hFFFF_FFFF);

    // R5 R6 sticky rising edge on source 9
    wr(8'h30, 32'h0000_0200);
    wr(8'h34, 32'h0000_0200);
    settle();
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h28, 32'h0000_0200);
    src_i[9] = 1'b1; settle();
    src_i[9] = 1'b0; settle();
    rd(8'h40, v); chk("R5 pending sticky", v, 32'h0000_0200);
    wr(8'h40, 32'h0000_0001);
    rd(8'h40, v); chk("R6 zero bits keep pending", v, 32'h0000_0200);
    wr(8'h40, 32'h0000_0200);
    rd(8'h40, v); chk("R6 clear pending", v, 32'h0);

    // R4 disabled active source masked
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h34, 32'h0);
    wr(8'h30, 32'h0);
    settle();
    rd(8'h40, v); chk("R4 disabled masked", v, 32'h0);

    // R7 R8 routing
    wr(8'h30, 32'h0000_1088);
    wr(8'h03, 32'h0000_0021);
    wr(8'h07, 32'h0000_0081);
    wr(8'h0C, 32'h0000_0042);
    wr(8'h28, 32'h0000_1088);
    settle();
    chk("R7 idle parents", {28'h0, parent_irq}, 32'h0);
    rd(8'h03, v); chk("R7 route readback", v, 32'h0000_0021);
    src_i[3] = 1'b1; settle();
    chk("R7 parent 1", {28'h0, parent_irq}, 32'h2);
    src_i[7] = 1'b1; settle();
    chk("R7 parents 1 and 3", {28'h0, parent_irq}, 32'hA);
    src_i[12] = 1'b1; settle();
    chk("R8 other core no effect", {28'h0, parent_irq}, 32'hA);
    rd(8'h40, v); chk("R8 status still shows", v, 32'h0000_1088);
    src_i[3] = 1'b0; settle();
    chk("R7 parent drops", {28'h0, parent_irq}, 32'h8);

    summary();
  end
endmodule